// File: doc/BRIEF.md
# Bus Fault Status Capture Unit

This unit watches the bus error reports coming out of a processor core and turns them into sticky status flags, plus a captured fault address where the kind of error allows one. Instruction-side errors are first recorded against the prefetch buffer slot that received the bad data. They become a visible fault only when that slot's instruction is actually issued. A flush throws the mark away.

Data-side errors come in two kinds. A precise error carries its address, and the unit captures that address along with a valid flag. An imprecise error has no usable address. It is held as pending while the core runs at a priority that masks bus faults. It turns active once the execution priority drops below the programmable bus fault priority. An error while unstacking on exception return sets its own flag and raises a one-cycle hold that keeps the stack pointer from being adjusted.

Software reads the flags and the address through a small registered port and clears the flags by writing ones.

Top module: `bus_fault_capture`

## Requirements
- R1: A prefetch error report (`pf_err_valid` with `pf_err_slot`) alone never sets the instruction flag (status bit 0). The flag is set when `iss_valid` issues a slot holding an error mark, and issuing consumes the mark.
- R2: A slot whose bit in `flush_mask` is 1 loses its error mark. A later issue of that slot sets no flag and gives no fault-active pulse.
- R3: Setting the instruction flag leaves the fault address register unchanged.
- R4: A precise error (`dp_err_valid`) sets status bit 1 and the address-valid bit 7, and loads `dp_err_addr` into the fault address register.
- R5: An imprecise error (`di_err_valid`) sets status bit 2 and leaves the fault address register unchanged.
- R6: A lower priority number means a more urgent level. After an imprecise error, `fault_pending` is 1 from the next cycle. While `exec_prio` <= `bf_prio` it stays pending with no fault-active pulse. In the first cycle it sees `exec_prio` > `bf_prio`, the unit pulses `fault_active` one cycle later and clears `fault_pending`.
- R7: A precise error arriving while an imprecise fault is pending sets bit 1 as well, so bits 1 and 2 read 1 together.
- R8: An unstacking error (`us_err_valid`) sets status bit 3, leaves the fault address unchanged, and pulses `sp_hold` for one cycle, one cycle later.
- R9: Register offset 0 is status (bits 0..3 and 7, write one to clear, write zero no effect). Offset 1 is the read-only fault address. `reg_rdata` shows offset `reg_addr` one cycle after it is presented.
- R10: When an event sets a flag in the same cycle a software write clears it, the flag ends up set.
- R11: Precise, instruction and unstacking errors give a `fault_active` pulse of exactly one cycle, in the cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_err_valid | input | 1 | Prefetch returned with a bus error |
| pf_err_slot | input | SLOT_W | Prefetch buffer slot of that fetch |
| flush_mask | input | SLOTS | Slots being flushed this cycle |
| iss_valid | input | 1 | An instruction is issued |
| iss_slot | input | SLOT_W | Slot of the issued instruction |
| dp_err_valid | input | 1 | Precise data bus error |
| dp_err_addr | input | ADDR_W | Address of the precise error |
| di_err_valid | input | 1 | Imprecise data bus error |
| us_err_valid | input | 1 | Bus error while unstacking |
| exec_prio | input | PRIO_W | Current execution priority (lower = more urgent) |
| bf_prio | input | PRIO_W | Programmed bus fault priority |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| fault_pending | output | 1 | Imprecise fault waiting for priority |
| fault_active | output | 1 | One-cycle fault-taken pulse |
| sp_hold | output | 1 | Suppress stack pointer update |

## Verification
The hardest state to reach is an imprecise fault held pending while a precise error lands on top of it. The priority must stay masked across several cycles, including the equal-priority boundary, before it is released. The stimulus programs a masking priority, injects the imprecise error, holds equality for a few cycles, and then fires a precise error. Only after that does it lower the priority and look for the late activation pulse. The deferred instruction flag needs a similar staging: a marked slot, an issue of a different slot, then the real issue, with a flushed slot run as the contrast.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int STAT_W      = 8;
  localparam int BIT_INSTR   = 0;
  localparam int BIT_PREC    = 1;
  localparam int BIT_IMPREC  = 2;
  localparam int BIT_UNSTK   = 3;
  localparam int BIT_AVALID  = 7;
  localparam logic [STAT_W-1:0] STAT_IMPL = 8'h8F;
  localparam int OFS_STATUS  = 0;
  localparam int OFS_ADDR    = 1;
endpackage

// File: rtl/bfc_slot_tracker.sv
module bfc_slot_tracker #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_err_valid,
  input  logic [SLOT_W-1:0] pf_err_slot,
  input  logic [SLOTS-1:0]  flush_mask,
  input  logic              iss_valid,
  input  logic [SLOT_W-1:0] iss_slot,
  output logic              issue_hit,
  output logic [SLOTS-1:0]  marks
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic drop, mark_new;
    assign drop     = flush_mask[g] || (iss_valid && (iss_slot == SLOT_W'(g)));
    assign mark_new = pf_err_valid && (pf_err_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (rst)           marks[g] <= 1'b0;
      else if (mark_new) marks[g] <= 1'b1;
      else if (drop)     marks[g] <= 1'b0;
    end
  end

  always_comb begin
    issue_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      if (iss_valid && (iss_slot == SLOT_W'(i)) && marks[i] && !flush_mask[i])
        issue_hit = 1'b1;
  end
endmodule

// File: rtl/bfc_imprecise_gate.sv
module bfc_imprecise_gate #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              di_err_valid,
  input  logic [PRIO_W-1:0] exec_prio,
  input  logic [PRIO_W-1:0] bf_prio,
  output logic              pending_q,
  output logic              activate
);
  assign activate = pending_q && (exec_prio > bf_prio);

  always_ff @(posedge clk) begin
    if (rst)               pending_q <= 1'b0;
    else if (di_err_valid) pending_q <= 1'b1;
    else if (activate)     pending_q <= 1'b0;
  end
endmodule

// File: rtl/bfc_regs.sv
module bfc_regs
  import bfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [ADDR_W-1:0] faddr_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [STAT_W-1:0] clr;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:STAT_W];
  assign clr = (wr && addr == REG_AW'(OFS_STATUS)) ? wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      faddr_q  <= '0;
    end else begin
      status_q <= ((status_q & ~clr) | set_vec) & STAT_IMPL;
      if (load_addr) faddr_q <= load_val;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == REG_AW'(OFS_STATUS))    rd_mux[STAT_W-1:0] = status_q;
    else if (addr == REG_AW'(OFS_ADDR)) rd_mux[ADDR_W-1:0] = faddr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bfc_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 8,
  parameter int REG_AW = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_err_valid,
  input  logic [SLOT_W-1:0] pf_err_slot,
  input  logic [SLOTS-1:0]  flush_mask,
  input  logic              iss_valid,
  input  logic [SLOT_W-1:0] iss_slot,
  input  logic              dp_err_valid,
  input  logic [ADDR_W-1:0] dp_err_addr,
  input  logic              di_err_valid,
  input  logic              us_err_valid,
  input  logic [PRIO_W-1:0] exec_prio,
  input  logic [PRIO_W-1:0] bf_prio,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fault_pending,
  output logic              fault_active,
  output logic              sp_hold
);
  logic              issue_hit, imp_activate;
  logic [SLOTS-1:0]  slot_marks;
  logic [STAT_W-1:0] set_vec, status_q;
  logic [ADDR_W-1:0] faddr_q;

  bfc_slot_tracker #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slots (
    .clk(clk), .rst(rst),
    .pf_err_valid(pf_err_valid), .pf_err_slot(pf_err_slot),
    .flush_mask(flush_mask),
    .iss_valid(iss_valid), .iss_slot(iss_slot),
    .issue_hit(issue_hit), .marks(slot_marks)
  );

  bfc_imprecise_gate #(.PRIO_W(PRIO_W)) u_imp (
    .clk(clk), .rst(rst),
    .di_err_valid(di_err_valid),
    .exec_prio(exec_prio), .bf_prio(bf_prio),
    .pending_q(fault_pending), .activate(imp_activate)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[BIT_INSTR]   = issue_hit;
    set_vec[BIT_PREC]    = dp_err_valid;
    set_vec[BIT_IMPREC]  = di_err_valid;
    set_vec[BIT_UNSTK]   = us_err_valid;
    set_vec[BIT_AVALID]  = dp_err_valid;
  end

  bfc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst),
    .set_vec(set_vec),
    .load_addr(dp_err_valid), .load_val(dp_err_addr),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status_q(status_q), .faddr_q(faddr_q), .rdata_q(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_active <= 1'b0;
      sp_hold      <= 1'b0;
    end else begin
      fault_active <= dp_err_valid || us_err_valid || issue_hit || imp_activate;
      sp_hold      <= us_err_valid;
    end
  end
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int ADDR_W = 32,
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              iss_valid,
  input logic              dp_err_valid,
  input logic [ADDR_W-1:0] dp_err_addr,
  input logic              di_err_valid,
  input logic              us_err_valid,
  input logic [PRIO_W-1:0] exec_prio,
  input logic [PRIO_W-1:0] bf_prio,
  input logic [7:0]        status_q,
  input logic [ADDR_W-1:0] faddr_q,
  input logic              fault_pending,
  input logic              fault_active,
  input logic              sp_hold
);
  a_r1_no_flag_without_issue: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> !$rose(status_q[0]));

  // R3, R5, R8: only a precise error may move the fault address
  a_r3_addr_kept: assert property (@(posedge clk) disable iff (rst)
    !dp_err_valid |=> $stable(faddr_q));

  a_r4_precise_capture: assert property (@(posedge clk) disable iff (rst)
    dp_err_valid |=> (faddr_q == $past(dp_err_addr)) && status_q[1] && status_q[7]);

  a_r5_imprecise_flag: assert property (@(posedge clk) disable iff (rst)
    di_err_valid |=> status_q[2] && fault_pending);

  a_r6_hold_pending: assert property (@(posedge clk) disable iff (rst)
    fault_pending && (exec_prio <= bf_prio) |=> fault_pending);

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    fault_pending && (exec_prio > bf_prio) && !di_err_valid |=> fault_active && !fault_pending);

  a_r8_sp_hold: assert property (@(posedge clk) disable iff (rst)
    us_err_valid |=> sp_hold);

  a_r8_sp_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !us_err_valid |=> !sp_hold);

  a_r11_no_spurious_active: assert property (@(posedge clk) disable iff (rst)
    !(dp_err_valid || us_err_valid || iss_valid || fault_pending) |=> !fault_active);
endmodule

bind bus_fault_capture bfc_checker #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst(rst),
  .iss_valid(iss_valid),
  .dp_err_valid(dp_err_valid), .dp_err_addr(dp_err_addr),
  .di_err_valid(di_err_valid), .us_err_valid(us_err_valid),
  .exec_prio(exec_prio), .bf_prio(bf_prio),
  .status_q(status_q), .faddr_q(faddr_q),
  .fault_pending(fault_pending), .fault_active(fault_active), .sp_hold(sp_hold)
);

// File: tb/bus_fault_capture_bench.sv
`timescale 1ns/100ps
module bus_fault_capture_bench;
  localparam int SLOTS = 4, ADDR_W = 32, DATA_W = 32, PRIO_W = 8, REG_AW = 2;
  localparam int SLOT_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic pf_err_valid = 0, iss_valid = 0, dp_err_valid = 0, di_err_valid = 0, us_err_valid = 0;
  logic [SLOT_W-1:0] pf_err_slot = '0, iss_slot = '0;
  logic [SLOTS-1:0]  flush_mask = '0;
  logic [ADDR_W-1:0] dp_err_addr = '0;
  logic [PRIO_W-1:0] exec_prio = '0, bf_prio = 8'd5;
  logic              reg_wr = 0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic fault_pending, fault_active, sp_hold;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] rd;
  localparam logic [31:0] ADDR_A = 32'h1234_5670, ADDR_B = 32'hCAFE_0000;

  always #2.5 clk = ~clk;

  bus_fault_capture #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                      .PRIO_W(PRIO_W), .REG_AW(REG_AW)) u_bus_fault_capture (
    .clk(clk), .rst(rst),
    .pf_err_valid(pf_err_valid), .pf_err_slot(pf_err_slot), .flush_mask(flush_mask),
    .iss_valid(iss_valid), .iss_slot(iss_slot),
    .dp_err_valid(dp_err_valid), .dp_err_addr(dp_err_addr),
    .di_err_valid(di_err_valid), .us_err_valid(us_err_valid),
    .exec_prio(exec_prio), .bf_prio(bf_prio),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fault_pending(fault_pending), .fault_active(fault_active), .sp_hold(sp_hold)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [REG_AW-1:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic write_reg(input logic [REG_AW-1:0] a, input logic [31:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    read_reg(0, rd); check("R9 reset status", rd, 32'h0);
    read_reg(1, rd); check("R9 reset address", rd, 32'h0);
    check("R11 reset active", {29'b0, fault_active, fault_pending, sp_hold}, 32'h0);
  endtask

  task automatic t_precise;
    dp_err_valid = 1; dp_err_addr = ADDR_A;
    @(negedge clk);
    dp_err_valid = 0;
    check("R11 precise pulse", {31'b0, fault_active}, 32'h1);
    @(negedge clk);
    check("R11 pulse single cycle", {31'b0, fault_active}, 32'h0);
    read_reg(0, rd); check("R4 status", rd, 32'h82);
    read_reg(1, rd); check("R4 address", rd, ADDR_A);
  endtask

  task automatic t_clear;
    write_reg(0, 32'h0);  read_reg(0, rd); check("R9 write zero no effect", rd, 32'h82);
    write_reg(0, 32'h02); read_reg(0, rd); check("R9 clear precise bit", rd, 32'h80);
    write_reg(0, 32'h80); read_reg(0, rd); check("R9 clear valid bit", rd, 32'h0);
    read_reg(1, rd); check("R9 address kept", rd, ADDR_A);
  endtask

  task automatic t_ierr;
    pf_err_valid = 1; pf_err_slot = 2;
    @(negedge clk);
    pf_err_valid = 0;
    check("R1 no pulse on prefetch", {31'b0, fault_active}, 32'h0);
    idle(2);
    read_reg(0, rd); check("R1 flag deferred", rd, 32'h0);
    iss_valid = 1; iss_slot = 1;
    @(negedge clk);
    check("R1 other slot issue", {31'b0, fault_active}, 32'h0);
    iss_slot = 2;
    @(negedge clk);
    check("R1 marked slot issue pulse", {31'b0, fault_active}, 32'h1);
    @(negedge clk);
    iss_valid = 0;
    check("R1 mark consumed", {31'b0, fault_active}, 32'h0);
    read_reg(0, rd); check("R1 instr flag", rd, 32'h01);
    read_reg(1, rd); check("R3 address unchanged", rd, ADDR_A);
    write_reg(0, 32'hFF);
  endtask

  task automatic t_flush;
    pf_err_valid = 1; pf_err_slot = 1;
    @(negedge clk);
    pf_err_valid = 0; flush_mask = 4'b0010;
    @(negedge clk);
    flush_mask = '0; iss_valid = 1; iss_slot = 1;
    @(negedge clk);
    iss_valid = 0;
    check("R2 flushed issue no pulse", {31'b0, fault_active}, 32'h0);
    read_reg(0, rd); check("R2 no flag", rd, 32'h0);
  endtask

  task automatic t_unstack;
    us_err_valid = 1;
    @(negedge clk);
    us_err_valid = 0;
    check("R8 sp_hold and active", {30'b0, sp_hold, fault_active}, 32'h3);
    @(negedge clk);
    check("R8 sp_hold single cycle", {31'b0, sp_hold}, 32'h0);
    read_reg(0, rd); check("R8 unstack flag", rd, 32'h08);
    read_reg(1, rd); check("R8 address unchanged", rd, ADDR_A);
    write_reg(0, 32'hFF);
  endtask

  task automatic t_imprecise;
    exec_prio = 2; bf_prio = 5;
    di_err_valid = 1;
    @(negedge clk);
    di_err_valid = 0;
    check("R6 pending not active", {30'b0, fault_active, fault_pending}, 32'h1);
    read_reg(0, rd); check("R5 imprecise flag", rd, 32'h04);
    read_reg(1, rd); check("R5 address unchanged", rd, ADDR_A);
    exec_prio = 5;
    idle(3);
    check("R6 equal priority holds", {30'b0, fault_active, fault_pending}, 32'h1);
    dp_err_valid = 1; dp_err_addr = ADDR_B;
    @(negedge clk);
    dp_err_valid = 0;
    check("R7 precise during pending", {30'b0, fault_active, fault_pending}, 32'h3);
    read_reg(0, rd); check("R7 both flags", rd, 32'h86);
    read_reg(1, rd); check("R7 precise address", rd, ADDR_B);
    check("R6 still pending", {30'b0, fault_active, fault_pending}, 32'h1);
    exec_prio = 6;
    @(negedge clk);
    check("R6 release pulse", {30'b0, fault_active, fault_pending}, 32'h2);
    @(negedge clk);
    check("R6 after release", {30'b0, fault_active, fault_pending}, 32'h0);
    write_reg(0, 32'hFF);
  endtask

  task automatic t_imprecise_open;
    exec_prio = 7; bf_prio = 5;
    di_err_valid = 1;
    @(negedge clk);
    di_err_valid = 0;
    check("R6 first cycle pending", {30'b0, fault_active, fault_pending}, 32'h1);
    @(negedge clk);
    check("R6 activation next cycle", {30'b0, fault_active, fault_pending}, 32'h2);
    write_reg(0, 32'hFF);
  endtask

  task automatic t_set_beats_clear;
    us_err_valid = 1;
    @(negedge clk);
    us_err_valid = 0;
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'hFF;
    dp_err_valid = 1; dp_err_addr = ADDR_A;
    @(negedge clk);
    reg_wr = 0; dp_err_valid = 0;
    read_reg(0, rd); check("R10 set beats clear", rd, 32'h82);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_precise;
    t_clear;
    t_ierr;
    t_flush;
    t_unstack;
    t_imprecise;
    t_imprecise_open;
    t_set_beats_clear;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule